// File: doc/BRIEF.md
# Periodic Real-Time Interrupt Timer

This block produces a periodic timeout from the oscillator clock and records each timeout in a sticky flag that software polls over a small register bus. A control register picks the period as the product of two divisions: a power-of-two prescaler chosen by a 3-bit exponent field and a modulo counter chosen by a 4-bit count field. Each expiry sets a flag that stays set until software writes a one to it. Software therefore need not catch the exact cycle of the event.

The bus is a synchronous port with one address bit, a write strobe, a read strobe and read data registered one cycle after the read. An interrupt output follows the flag. Writing the control register restarts both dividers, so the first timeout after a write comes one full period later. A zero exponent field stops the timer.

Top module: `periodic_tick_timer`

## Requirements
- R1: After reset, the control register (address 0) reads 0x00, the flag register (address 1) reads 0x00 and irq_o is 0, so the timer is stopped.
- R2: With control value c (count field n = c[3:0], exponent m = c[6:4], m != 0), the flag is set exactly (n+1)·2^(m+BASE_EXP) cycles after the control write edge. BASE_EXP defaults to 9, which gives 81920 cycles for 0x49 and 2^20 cycles for 0x7F.
- R3: Timeouts repeat every (n+1)·2^(m+BASE_EXP) cycles while the control register is unchanged.
- R4: With m = 0, no timeout ever occurs, whatever the count field holds.
- R5: Once set, the flag stays 1 until a clearing write.
- R6: A write to address 1 with data bit 7 = 1 clears the flag. A write to address 1 with bit 7 = 0 leaves the flag unchanged.
- R7: If a timeout and a clearing write fall in the same cycle, the flag ends at 1.
- R8: Control bit 7 ignores writes and reads 0. Flag register bits 6:0 always read 0, and the flag itself is bit 7.
- R9: Read data appears on rdata_o in the cycle after rd_en_i. rdata_o is 0x00 after any cycle without a read.
- R10: irq_o equals the flag value that a read of address 1 returns in bit 7.
- R11: A control write during a running period discards the elapsed count and starts a new full period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | oscillator clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| addr_i | input | 1 | register select: 0 control, 1 flag |
| wr_en_i | input | 1 | write strobe |
| wdata_i | input | 8 | write data |
| rd_en_i | input | 1 | read strobe |
| rdata_o | output | 8 | read data, one cycle after rd_en_i |
| irq_o | output | 1 | interrupt request, follows the flag |

## Verification
The bench builds the block with BASE_EXP = 1 instead of 9. The shortest period is then 4 cycles and the longest, control value 0x7F, is 4096 cycles. At these lengths the bench can measure exact periods for random control values, the 0x49 and 0x7F encodings and restarts in the middle of a period. It can also place a clearing write exactly on a timeout edge, which tests the rule that the set takes priority over the clear.

// File: rtl/ptt_pkg.sv
package ptt_pkg;
  localparam int REG_W    = 8;
  localparam int N_W      = 4;
  localparam int M_W      = 3;
  localparam int ADDR_W   = 1;
  localparam int FLAG_BIT = 7;
  localparam logic [ADDR_W-1:0] CTRL_ADDR = 1'b0;
  localparam logic [ADDR_W-1:0] FLAG_ADDR = 1'b1;

  typedef struct packed {
    logic [M_W-1:0] m;
    logic [N_W-1:0] n;
  } ctrl_t;
endpackage

// File: rtl/ptt_prescaler.sv
module ptt_prescaler #(
  parameter int BASE_EXP = 9,
  parameter int M_W      = 3
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           restart_i,
  input  logic [M_W-1:0] m_i,
  output logic           tick_o
);
  localparam int PRE_W = BASE_EXP + (2**M_W) - 1;

  logic [PRE_W-1:0] cnt_q;
  logic [PRE_W-1:0] mask;

  always_comb begin
    mask = '0;
    for (int i = 0; i < PRE_W; i++)
      if (i < int'(m_i) + BASE_EXP) mask[i] = 1'b1;
  end

  assign tick_o = (m_i != '0) && ((cnt_q & mask) == mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        cnt_q <= '0;
    else if (restart_i || m_i == '0)    cnt_q <= '0;
    else                                cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/ptt_divider.sv
module ptt_divider #(
  parameter int N_W = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           restart_i,
  input  logic           tick_i,
  input  logic [N_W-1:0] limit_i,
  output logic           expire_o
);
  logic [N_W-1:0] cnt_q;

  assign expire_o = tick_i && (cnt_q == limit_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (restart_i) cnt_q <= '0;
    else if (tick_i)    cnt_q <= (cnt_q == limit_i) ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/ptt_sticky_flag.sv
module ptt_sticky_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  // set has priority over a coincident clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;
    else if (clr_i) flag_o <= 1'b0;
  end
endmodule

// File: rtl/periodic_tick_timer.sv
module periodic_tick_timer #(
  parameter int BASE_EXP = 9
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [ptt_pkg::ADDR_W-1:0] addr_i,
  input  logic                       wr_en_i,
  input  logic [ptt_pkg::REG_W-1:0]  wdata_i,
  input  logic                       rd_en_i,
  output logic [ptt_pkg::REG_W-1:0]  rdata_o,
  output logic                       irq_o
);
  import ptt_pkg::*;

  ctrl_t          ctrl_q;
  logic [M_W-1:0] ctrl_m_w;
  logic           ctrl_wr;
  logic           flag_clr;
  logic           tick_w;
  logic           expire_w;
  logic           flag_w;
  logic [REG_W-1:0] rd_mux;

  assign ctrl_wr  = wr_en_i && (addr_i == CTRL_ADDR);
  assign flag_clr = wr_en_i && (addr_i == FLAG_ADDR) && wdata_i[FLAG_BIT];
  assign ctrl_m_w = ctrl_q.m;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ctrl_q <= '0;
    else if (ctrl_wr) ctrl_q <= ctrl_t'(wdata_i[M_W+N_W-1:0]);
  end

  ptt_prescaler #(.BASE_EXP(BASE_EXP), .M_W(M_W)) u_pre (
    .clk_i, .rst_ni, .restart_i(ctrl_wr), .m_i(ctrl_q.m), .tick_o(tick_w)
  );

  ptt_divider #(.N_W(N_W)) u_div (
    .clk_i, .rst_ni, .restart_i(ctrl_wr), .tick_i(tick_w),
    .limit_i(ctrl_q.n), .expire_o(expire_w)
  );

  ptt_sticky_flag u_flag (
    .clk_i, .rst_ni, .set_i(expire_w), .clr_i(flag_clr), .flag_o(flag_w)
  );

  always_comb begin
    rd_mux = '0;
    if (addr_i == CTRL_ADDR) rd_mux[M_W+N_W-1:0] = ctrl_q;
    else                     rd_mux[FLAG_BIT]    = flag_w;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_o <= '0;
    else         rdata_o <= rd_en_i ? rd_mux : '0;
  end

  assign irq_o = flag_w;
endmodule

// File: rtl/ptt_timer_chk.sv
module ptt_timer_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       addr_i,
  input logic       wr_en_i,
  input logic [7:0] wdata_i,
  input logic       rd_en_i,
  input logic [7:0] rdata_o,
  input logic       irq_o,
  input logic       expire_i,
  input logic [2:0] m_i
);
  logic clr_req;
  assign clr_req = wr_en_i && addr_i && wdata_i[7];

  // R4
  off_no_expire_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_i == 3'd0) |-> !expire_i);
  // R5
  flag_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !clr_req) |=> irq_o);
  // R6
  flag_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_req && !expire_i) |=> !irq_o);
  // R7
  set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_i |=> irq_o);
  // R8
  flag_low_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i) |=> (rdata_o[6:0] == 7'd0));
  // R8
  ctrl_rsvd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !addr_i) |=> !rdata_o[7]);
  // R9
  idle_rdata_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> (rdata_o == 8'd0));
  // R10
  irq_matches_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i) |=> (rdata_o[7] == $past(irq_o)));
endmodule

bind periodic_tick_timer ptt_timer_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wr_en_i(wr_en_i),
  .wdata_i(wdata_i), .rd_en_i(rd_en_i), .rdata_o(rdata_o), .irq_o(irq_o),
  .expire_i(expire_w), .m_i(ctrl_m_w)
);

// File: tb/periodic_tick_timer_test.sv
module periodic_tick_timer_test;
  localparam int BE = 1;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       addr = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wdata = 8'd0;
  logic       rd_en = 1'b0;
  logic [7:0] rdata;
  logic       irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  periodic_tick_timer #(.BASE_EXP(BE)) uut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr_en),
    .wdata_i(wdata), .rd_en_i(rd_en), .rdata_o(rdata), .irq_o(irq)
  );

  function automatic int period_of(input logic [7:0] c);
    return (int'(c[3:0]) + 1) << (int'(c[6:4]) + BE);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // all tasks begin and end at a negedge
  task automatic wr(input logic a, input logic [7:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; wdata = 8'd0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  // counts negedges until irq is seen, up to lim
  task automatic wait_irq(input int lim, output int cnt);
    cnt = -1;
    for (int c = 1; c <= lim; c++) begin
      @(negedge clk);
      if (irq) begin cnt = c; break; end
    end
  endtask

  task automatic start(input logic [7:0] c);
    wr(1'b0, c);
    wr(1'b1, 8'h80);
  endtask

  task automatic measure(input string req, input logic [7:0] c);
    int p, got;
    p = period_of(c);
    start(c);
    wait_irq(p + 8, got);
    check(req, got, p - 1);
  endtask

  initial begin
    logic [7:0] d;
    int got, p;
    logic [7:0] c;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 irq", irq, 0);
    rd(1'b0, d); check("R1 ctrl", d, 8'h00);
    rd(1'b1, d); check("R1 flag", d, 8'h00);
    wait_irq(300, got); check("R1 idle no timeout", got, -1);

    // R2 documented encodings
    measure("R2 0x49", 8'h49);
    measure("R2 0x7F", 8'h7F);

    // R10 / R8 flag read while set
    check("R10 irq", irq, 1);
    rd(1'b1, d); check("R8 R10 flag read", d, 8'h80);

    // R5 sticky, R6 zero write ignored
    repeat (40) @(negedge clk);
    check("R5 sticky", irq, 1);
    wr(1'b1, 8'h7F);
    check("R6 zero write", irq, 1);
    wr(1'b1, 8'h80);
    check("R6 clear", irq, 0);
    rd(1'b1, d); check("R10 cleared read", d, 8'h00);

    // R8 reserved control bit, R9 idle read data
    wr(1'b0, 8'hFF);
    rd(1'b0, d); check("R8 ctrl bit7", d, 8'h7F);
    @(negedge clk); check("R9 idle rdata", rdata, 0);

    // R4 timer off for any count field
    start(8'h0F);
    wait_irq(5000, got); check("R4 off 0x0F", got, -1);
    start(8'h80);
    wait_irq(500, got); check("R4 off 0x80", got, -1);

    // R11 restart mid-period
    start(8'h12);
    repeat (7) @(negedge clk);
    measure("R11 restart", 8'h12);

    // R7 clear lands on timeout edge: ctrl 0x10, period 4
    wr(1'b0, 8'h10);
    wr(1'b1, 8'h80);
    repeat (2) @(negedge clk);
    wr(1'b1, 8'h80);
    check("R7 set wins", irq, 1);
    wr(1'b1, 8'h80);
    check("R6 clear after tie", irq, 0);

    // R2 R3 random control values
    for (int k = 0; k < 12; k++) begin
      c = {1'b0, 3'(1 + $urandom_range(4)), 4'($urandom_range(15))};
      p = period_of(c);
      measure("R2 random", c);
      wr(1'b1, 8'h80);
      wait_irq(p + 8, got);
      check("R3 repeat", got, p - 1);
      rd(1'b0, d); check("R8 ctrl readback", d, c);
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=expired expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule